// File: doc/BRIEF.md
# Peripheral Request to Channel Mapper

This block sits between a set of peripheral DMA request lines and a bank of DMA channels. Every request line owns a small mapping register that holds a valid flag and a target channel number. While a line's mapping is valid, its request is steered onto the chosen channel. Lines that point at the same channel are merged. Software programs the mapping through a simple write port and a registered read port. The mapping registers occupy two address windows: one for the lower 64 lines and one for the upper 64.

Each channel gets three outputs. The first is the routed request, produced combinationally in the same cycle. The second is a registered pending copy of that request. The third is an advance permit. A channel that is set for peripheral flow control may advance only while its routed request is high. A channel without flow control, such as one doing a memory-to-memory copy, is always permitted to advance and ignores requests.

Top module: `req_chan_mapper`

## Requirements
- R1: While `rst_n` is low at a clock edge, every mapping register is cleared to valid=0 and channel=0, and `rd_data` is cleared to zero. After reset, no request line reaches any channel, and every mapping reads back as zero.
- R2: A write to byte address 0x100 + 4×line, for line 0 to 63, stores `wr_data` bit 7 as the valid flag and `wr_data` bits 4:0 as the channel number of that line.
- R3: A write to byte address 0x1100 + 4×(line − 64), for line 64 to 127, stores the valid flag and the channel number of that line in the same bit positions as R2.
- R4: A write to an address outside both windows, or to an address whose two low bits are not zero, changes no mapping.
- R5: A read issues on the clock edge where `rd_en` is high. One edge later, `rd_data` holds the addressed mapping with the valid flag in bit 7, the channel in bits 4:0, and zeros in all other bits. A read of an unmapped address returns zero. `rd_data` keeps its value until the next read.
- R6: A request line whose mapping is not valid has no effect on any channel.
- R7: `ch_req[c]` is the OR of all request lines whose valid mapping names channel c. It follows `req_in` in the same cycle.
- R8: `ch_pend` equals the value `ch_req` had at the previous clock edge.
- R9: For a channel with `flow_en[c]` = 1, `ch_go[c]` equals `ch_req[c]`. For a channel with `flow_en[c]` = 0, `ch_go[c]` is 1 regardless of requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Mapping register write strobe |
| wr_addr | input | 13 | Byte address of the write |
| wr_data | input | 32 | Write data; bit 7 is the valid flag, bits 4:0 are the channel |
| rd_en | input | 1 | Mapping register read strobe |
| rd_addr | input | 13 | Byte address of the read |
| rd_data | output | 32 | Read result, registered |
| req_in | input | NUM_LINES (128) | Peripheral request lines |
| flow_en | input | NUM_CH (32) | Per-channel flow-control enable |
| ch_req | output | NUM_CH (32) | Routed request per channel |
| ch_pend | output | NUM_CH (32) | Registered request-pending status per channel |
| ch_go | output | NUM_CH (32) | Per-channel advance permit |

## Verification
The hardest case to reach is a channel driven at once by a low-window line and a high-window line, while other lines have valid and invalid mappings that point elsewhere. This case exercises the merge and the two address windows together. The stimulus table first programs lines at both edges of each window, including an invalid line and stray addresses. Request patterns are then applied that light up one contributor, the other contributor, or both. A full all-lines pattern is also applied and compared against a model kept in the bench.

// File: rtl/req_map_pkg.sv
package req_map_pkg;
  localparam int unsigned ADDR_W    = 13;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned CHF_W     = 5;
  localparam int unsigned LINE_W    = 7;
  localparam int unsigned WIN_LINES = 64;
  localparam int unsigned LOW_BASE  = 32'h100;
  localparam int unsigned HIGH_BASE = 32'h1100;
  localparam int unsigned VLD_BIT   = 7;

  typedef struct packed {
    logic              vld;
    logic [CHF_W-1:0]  ch;
  } map_ent_t;

  typedef struct packed {
    logic              hit;
    logic [LINE_W-1:0] line;
  } dec_t;

  // Map a byte address onto a line index, honouring both windows.
  function automatic dec_t decode_addr(input logic [ADDR_W-1:0] a,
                                       input int unsigned nlines);
    dec_t        r;
    int unsigned ai;
    int unsigned idx;
    r   = '0;
    ai  = 32'(a);
    idx = 0;
    if (a[1:0] == 2'b00) begin
      if (ai >= LOW_BASE && ai < LOW_BASE + 4 * WIN_LINES) begin
        idx   = (ai - LOW_BASE) >> 2;
        r.hit = (idx < nlines);
      end else if (ai >= HIGH_BASE && ai < HIGH_BASE + 4 * WIN_LINES) begin
        idx   = WIN_LINES + ((ai - HIGH_BASE) >> 2);
        r.hit = (idx < nlines);
      end
    end
    r.line = LINE_W'(idx);
    return r;
  endfunction

  function automatic map_ent_t unpack_wr(input logic [DATA_W-1:0] d);
    map_ent_t e;
    e.vld = d[VLD_BIT];
    e.ch  = d[CHF_W-1:0];
    return e;
  endfunction

  function automatic logic [DATA_W-1:0] pack_rd(input map_ent_t e);
    logic [DATA_W-1:0] d;
    d                = '0;
    d[VLD_BIT]       = e.vld;
    d[CHF_W-1:0]     = e.ch;
    return d;
  endfunction
endpackage

// File: rtl/req_map_regs.sv
module req_map_regs
  import req_map_pkg::*;
#(
  parameter int unsigned NUM_LINES = 128
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                wr_en,
  input  logic [ADDR_W-1:0]                   wr_addr,
  input  logic [DATA_W-1:0]                   wr_data,
  input  logic                                rd_en,
  input  logic [ADDR_W-1:0]                   rd_addr,
  output logic [DATA_W-1:0]                   rd_data,
  output logic [NUM_LINES-1:0]                map_vld,
  output logic [NUM_LINES-1:0][CHF_W-1:0]     map_ch
);
  dec_t     wr_dec, rd_dec;
  logic     wr_hit, rd_hit;
  map_ent_t wr_ent, rd_ent;
  logic [DATA_W-1:0] rd_q;

  always_comb begin
    wr_dec = decode_addr(wr_addr, NUM_LINES);
    rd_dec = decode_addr(rd_addr, NUM_LINES);
    wr_hit = wr_en && wr_dec.hit;
    wr_ent = unpack_wr(wr_data);
    rd_hit = rd_dec.hit;
    rd_ent.vld = map_vld[rd_dec.line];
    rd_ent.ch  = map_ch[rd_dec.line];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      map_vld <= '0;
      map_ch  <= '0;
    end else if (wr_hit) begin
      map_vld[wr_dec.line] <= wr_ent.vld;
      map_ch[wr_dec.line]  <= wr_ent.ch;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      rd_q <= '0;
    else if (rd_en)
      rd_q <= rd_hit ? pack_rd(rd_ent) : '0;
  end

  assign rd_data = rd_q;

  a_r1_reset_clears: assert property (@(posedge clk)
    !rst_n |=> (map_vld == '0 && map_ch == '0 && rd_data == '0));

  a_r4_stray_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_hit) |=> ($stable(map_vld) && $stable(map_ch)));

  a_r5_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_en) |=> $stable(rd_data));
endmodule

// File: rtl/req_route_xbar.sv
module req_route_xbar
  import req_map_pkg::*;
#(
  parameter int unsigned NUM_LINES = 128,
  parameter int unsigned NUM_CH    = 32
) (
  input  logic [NUM_LINES-1:0]            req_in,
  input  logic [NUM_LINES-1:0]            map_vld,
  input  logic [NUM_LINES-1:0][CHF_W-1:0] map_ch,
  output logic [NUM_CH-1:0]               ch_req
);
  logic [NUM_LINES-1:0] live;
  assign live = req_in & map_vld;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam logic [CHF_W-1:0] CID = CHF_W'(c);
    logic [NUM_LINES-1:0] hits;
    for (genvar l = 0; l < NUM_LINES; l++) begin : g_ln
      assign hits[l] = live[l] && (map_ch[l] == CID);
    end
    assign ch_req[c] = |hits;
  end
endmodule

// File: rtl/req_chan_gate.sv
module req_chan_gate #(
  parameter int unsigned NUM_CH = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] ch_req,
  input  logic [NUM_CH-1:0] flow_en,
  output logic [NUM_CH-1:0] ch_pend,
  output logic [NUM_CH-1:0] ch_go
);
  always_ff @(posedge clk) begin
    if (!rst_n) ch_pend <= '0;
    else        ch_pend <= ch_req;
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_go
    assign ch_go[c] = flow_en[c] ? ch_req[c] : 1'b1;
  end

  a_r8_pend_lags: assert property (@(posedge clk) disable iff (!rst_n)
    ch_pend == $past(ch_req));

  a_r9_go_needs_flow: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_go != '1) |-> (flow_en != '0));
endmodule

// File: rtl/req_chan_mapper.sv
module req_chan_mapper
  import req_map_pkg::*;
#(
  parameter int unsigned NUM_LINES = 128,
  parameter int unsigned NUM_CH    = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic [DATA_W-1:0]     wr_data,
  input  logic                  rd_en,
  input  logic [ADDR_W-1:0]     rd_addr,
  output logic [DATA_W-1:0]     rd_data,
  input  logic [NUM_LINES-1:0]  req_in,
  input  logic [NUM_CH-1:0]     flow_en,
  output logic [NUM_CH-1:0]     ch_req,
  output logic [NUM_CH-1:0]     ch_pend,
  output logic [NUM_CH-1:0]     ch_go
);
  logic [NUM_LINES-1:0]            map_vld;
  logic [NUM_LINES-1:0][CHF_W-1:0] map_ch;

  req_map_regs #(.NUM_LINES(NUM_LINES)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .map_vld(map_vld), .map_ch(map_ch)
  );

  req_route_xbar #(.NUM_LINES(NUM_LINES), .NUM_CH(NUM_CH)) u_xbar (
    .req_in(req_in), .map_vld(map_vld), .map_ch(map_ch), .ch_req(ch_req)
  );

  req_chan_gate #(.NUM_CH(NUM_CH)) u_gate (
    .clk(clk), .rst_n(rst_n), .ch_req(ch_req), .flow_en(flow_en),
    .ch_pend(ch_pend), .ch_go(ch_go)
  );

  a_r7_quiet_lines: assert property (@(posedge clk) disable iff (!rst_n)
    (req_in == '0) |-> (ch_req == '0));

  a_r6_invalid_silent: assert property (@(posedge clk) disable iff (!rst_n)
    ((req_in & map_vld) == '0) |-> (ch_req == '0));
endmodule

// File: tb/req_chan_mapper_test.sv
module req_chan_mapper_test;
  localparam int NL = 128;
  localparam int NC = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [12:0] wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [NL-1:0] req_in = '0;
  logic [NC-1:0] flow_en = '0;
  logic [NC-1:0] ch_req, ch_pend, ch_go;

  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  req_chan_mapper #(.NUM_LINES(NL), .NUM_CH(NC)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .req_in(req_in),
    .flow_en(flow_en), .ch_req(ch_req), .ch_pend(ch_pend), .ch_go(ch_go)
  );

  typedef struct packed {
    logic [12:0] a;
    logic [31:0] d;
    logic [7:0]  ln;
    logic        ign;
    logic [31:0] rd;
  } vec_t;

  localparam vec_t VEC [10] = '{
    '{13'h0100, 32'h0000_0085, 8'd0,   1'b0, 32'h85},
    '{13'h0104, 32'hFFFF_FF83, 8'd1,   1'b0, 32'h83},
    '{13'h01FC, 32'h0000_009F, 8'd63,  1'b0, 32'h9F},
    '{13'h1100, 32'h0000_0085, 8'd64,  1'b0, 32'h85},
    '{13'h11FC, 32'h0000_0080, 8'd127, 1'b0, 32'h80},
    '{13'h0108, 32'h0000_0007, 8'd2,   1'b0, 32'h07},
    '{13'h0102, 32'h0000_0091, 8'd0,   1'b1, 32'h00},
    '{13'h0300, 32'h0000_0092, 8'd0,   1'b1, 32'h00},
    '{13'h1000, 32'h0000_0093, 8'd0,   1'b1, 32'h00},
    '{13'h1200, 32'h0000_0094, 8'd0,   1'b1, 32'h00}
  };

  logic       mv [NL];
  logic [4:0] mc [NL];
  logic [NC-1:0] last_req;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [NC-1:0] model_req(input logic [NL-1:0] r);
    logic [NC-1:0] o = '0;
    for (int l = 0; l < NL; l++)
      if (r[l] && mv[l]) o[mc[l]] = 1'b1;
    return o;
  endfunction

  task automatic wr(input logic [12:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [12:0] a, output logic [31:0] v);
    @(negedge clk); rd_en = 1'b1; rd_addr = a;
    @(negedge clk); rd_en = 1'b0; v = rd_data;
  endtask

  task automatic route(input string tag, input logic [NL-1:0] r);
    logic [NC-1:0] e;
    @(negedge clk); req_in = r; #1;
    e = model_req(r);
    chk({tag, " R7 ch_req"}, ch_req, e);
    chk({tag, " R9 ch_go"}, ch_go, e | ~flow_en);
    @(negedge clk);
    chk({tag, " R8 ch_pend"}, ch_pend, e);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    for (int l = 0; l < NL; l++) begin mv[l] = 1'b0; mc[l] = '0; end
    req_in = '1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset state with every line requesting
    chk("R1 ch_req after reset", ch_req, '0);
    chk("R1 rd_data after reset", rd_data, '0);
    chk("R9 ch_go no flow", ch_go, '1);
    req_in = '0;

    // Table: R2/R3 programming, R4 strays, R5 readback
    for (int i = 0; i < 10; i++) begin
      wr(VEC[i].a, VEC[i].d);
      if (!VEC[i].ign) begin
        mv[VEC[i].ln] = VEC[i].d[7];
        mc[VEC[i].ln] = VEC[i].d[4:0];
      end
    end
    for (int i = 0; i < 10; i++) begin
      rd(VEC[i].a, v);
      chk($sformatf("R2 R3 R4 R5 read %h", VEC[i].a), v, VEC[i].rd);
    end
    // R4: stray writes must not have hit line 0
    rd(13'h0100, v);
    chk("R4 line0 untouched", v, 32'h85);

    // R6/R7 routing patterns
    route("single low line0", 128'h1);
    route("single high line64", 128'h1 << 64);
    route("R7 merge line0+64", (128'h1 << 64) | 128'h1);
    route("R6 invalid line2", 128'h4);
    route("line127 to ch0", 128'h1 << 127);
    route("line63 to ch31", 128'h1 << 63);
    route("line1 to ch3", 128'h2);
    route("all lines", '1);

    // R9: flow control on channel 5 and 31
    flow_en = 32'h8000_0020;
    route("R9 flow no req", '0);
    route("R9 flow req", 128'h1);
    route("R9 flow all", '1);
    flow_en = '0;

    // R5: rd_data holds without rd_en
    @(negedge clk); rd_addr = 13'h01FC;
    @(negedge clk);
    chk("R5 rd_data held", rd_data, 32'h85);

    // R1: second reset with requests active
    @(negedge clk); rst_n = 1'b0; req_in = '1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    for (int l = 0; l < NL; l++) begin mv[l] = 1'b0; mc[l] = '0; end
    #1;
    chk("R1 ch_req after reset2", ch_req, '0);
    rd(13'h0100, v);
    chk("R1 line0 cleared", v, '0);
    rd(13'h11FC, v);
    chk("R1 line127 cleared", v, '0);
    req_in = '0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule